// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block drives the transmit side of a Media Independent Interface from the MAC end. It takes frame bytes through a valid/ready/last handshake and turns each frame into a nibble stream on a transmit enable and a 4-bit data bus. It first sends a fixed preamble and a start-of-frame nibble, then sends each payload byte as two nibbles. After the frame it holds the pins idle for a minimum gap. Its only clock is the transmit clock that the PHY supplies. That clock is slow in 10 Mbps mode and ten times faster in 100 Mbps mode, and the same logic serves both.

The frame bytes must already carry their CRC and any padding. Once a frame's first byte is offered, the source must keep `in_valid` high with no gaps until the byte flagged `in_last` has been accepted. A byte is taken on a rising clock edge when both `in_ready` and `in_valid` are high. This happens at most once every two clocks.

Top module: `mii_tx_nibbler`

## Requirements
- R1: While reset is active, and afterwards until a frame starts, `txen`, `txd` and `in_ready` are all low.
- R2: When `in_valid` is high in the idle state, `txen` rises on the next clock edge. The pins then carry `PRE_NIBBLES` nibbles of value 0x5, followed by one nibble of value 0xD.
- R3: Each accepted byte appears as two consecutive nibbles: first `in_data[3:0]`, then `in_data[7:4]`.
- R4: `in_ready` is high for exactly one clock per byte of the frame. It is never high on two consecutive clocks. The first byte is taken during the 0xD nibble, and each later byte during the high nibble of the byte before it.
- R5: `txen` stays high from the first preamble nibble through the high nibble of the last byte, and is low on the very next clock. A frame of N bytes holds `txen` high for `PRE_NIBBLES`+1+2N clocks.
- R6: While `txen` is low, `txd` is 0. While `in_valid` is low, changes on `in_data` have no effect on the pins.
- R7: Between frames, `txen` stays low for at least `GAP_NIBBLES` clocks. If the next frame is already offered when the gap ends, exactly `GAP_NIBBLES` low clocks separate the two frames.
- R8: While the gap is running, `in_ready` stays low, so a byte offered then is held off.
- R9: A frame of a single byte (with `in_last` set on its first byte) produces preamble, 0xD, two data nibbles, and then the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY-supplied transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Frame byte offered by the MAC |
| in_valid | input | 1 | `in_data` holds a valid frame byte |
| in_last | input | 1 | The offered byte is the final byte of the frame |
| in_ready | output | 1 | The offered byte is taken at this clock edge |
| txen | output | 1 | Transmit enable to the PHY |
| txd | output | 4 | Transmit nibble to the PHY |

## Verification
The bench builds the block with its default parameters: a 15-nibble preamble and a 24-clock gap. With these values it checks the exact preamble and frame lengths and the exact gap count when two frames are queued back to back. It also sends frames of 1 byte and 32 bytes, so the single-byte path, with no handshake during the high nibble, and a long run of byte handoffs at the two-clock rate are both covered.

// File: rtl/mii_tx_nibbler.sv
module mii_tx_nibbler #(
  parameter int PRE_NIBBLES = 15,
  parameter int GAP_NIBBLES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       txen,
  output logic [3:0] txd
);
  localparam int CMAX = (PRE_NIBBLES > GAP_NIBBLES) ? PRE_NIBBLES : GAP_NIBBLES;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] PRE_END = CW'(PRE_NIBBLES - 1);
  localparam logic [CW-1:0] GAP_END = CW'(GAP_NIBBLES - 1);
  localparam logic [CW-1:0] GAP_SAT = CW'(GAP_NIBBLES);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_LO, S_HI, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    byte_q;
  logic          last_q;

  assign in_ready = (st == S_SFD) || (st == S_HI && !last_q);
  assign txen     = (st == S_PRE) || (st == S_SFD) || (st == S_LO) || (st == S_HI);

  always_comb begin
    case (st)
      S_PRE:   txd = 4'h5;
      S_SFD:   txd = 4'hD;
      S_LO:    txd = byte_q[3:0];
      S_HI:    txd = byte_q[7:4];
      default: txd = 4'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      byte_q <= '0;
      last_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st  <= S_PRE;
          cnt <= '0;
        end
        S_PRE: begin
          if (cnt == PRE_END) st <= S_SFD;
          else cnt <= cnt + 1'b1;
        end
        S_SFD: begin
          byte_q <= in_data;
          last_q <= in_last;
          st     <= S_LO;
        end
        S_LO: st <= S_HI;
        S_HI: begin
          if (last_q) begin
            st  <= S_GAP;
            cnt <= '0;
          end else begin
            byte_q <= in_data;
            last_q <= in_last;
            st     <= S_LO;
          end
        end
        S_GAP: begin
          if (cnt == GAP_END) begin
            st  <= in_valid ? S_PRE : S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] low_run;
  logic          sent_one;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      sent_one <= 1'b0;
    end else begin
      sent_one <= sent_one | txen;
      if (txen) low_run <= '0;
      else if (low_run != GAP_SAT) low_run <= low_run + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> (txd == 4'h0 && !in_ready)); // R6
  AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> txd == 4'h5); // R2
  AST_READY_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R4
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen) |-> $past(st == S_HI && last_q)); // R5
  AST_GAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txen) && sent_one) |-> low_run == GAP_SAT); // R7
endmodule

// File: tb/mii_tx_nibbler_test.sv
module mii_tx_nibbler_test;
  localparam int PRE = 15;
  localparam int GAP = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       txen;
  logic [3:0] txd;

  mii_tx_nibbler #(.PRE_NIBBLES(PRE), .GAP_NIBBLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .txen(txen), .txd(txd));

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [3:0] cap [0:255];
  int cap_n = 0;
  int gap_before = 0;
  int low_run = 0;
  int frames_done = 0;
  int ready_cnt = 0;
  int ready_low = 0;
  int ready_consec = 0;
  int zero_viol = 0;
  bit prev_en = 1'b0;
  bit prev_rdy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (txen) begin
        if (!prev_en) begin
          cap_n = 0;
          gap_before = low_run;
          ready_cnt = 0;
        end
        if (cap_n < 256) cap[cap_n] = txd;
        cap_n++;
        if (in_ready) ready_cnt++;
        low_run = 0;
      end else begin
        if (txd != 4'h0) zero_viol++;
        if (in_ready) ready_low++;
        if (prev_en) frames_done++;
        low_run++;
      end
      if (in_ready && prev_rdy) ready_consec++;
      prev_en = txen;
      prev_rdy = in_ready;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int k);
    return 8'((seed * 37 + k * 29 + 11) & 255);
  endfunction

  task automatic send_frame(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      in_data  = byte_of(seed, k);
      in_last  = (k == n - 1);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic check_frame(input int n, input int seed, input string tag);
    int bad_pre = 0;
    int bad_dat = 0;
    int first_bad = 0;
    int exp_first = 0;
    check(cap_n == PRE + 1 + 2 * n, {"R5 length ", tag}, cap_n, PRE + 1 + 2 * n);
    for (int i = 0; i < cap_n && i < 256; i++) begin
      logic [3:0] e;
      logic [7:0] b;
      if (i < PRE) e = 4'h5;
      else if (i == PRE) e = 4'hD;
      else begin
        b = byte_of(seed, (i - PRE - 1) / 2);
        e = ((i - PRE - 1) % 2 == 0) ? b[3:0] : b[7:4];
      end
      if (cap[i] != e) begin
        if (i <= PRE) bad_pre++;
        else begin
          if (bad_dat == 0) begin first_bad = int'(cap[i]); exp_first = int'(e); end
          bad_dat++;
        end
      end
    end
    check(bad_pre == 0, {"R2 preamble/SFD mismatches ", tag}, bad_pre, 0);
    check(bad_dat == 0, {"R3 data nibble order ", tag}, first_bad, exp_first);
    check(ready_cnt == n, {"R4 ready pulses ", tag}, ready_cnt, n);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!txen && txd == 0 && !in_ready, "R1 outputs in reset", int'({txen, txd, in_ready}), 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!txen && txd == 0 && !in_ready, "R1 outputs after reset", int'({txen, txd, in_ready}), 0);
  endtask

  task automatic t_idle_noise();
    int bad = 0;
    for (int i = 0; i < 40; i++) begin
      in_data = 8'(i * 53 + 7);
      @(negedge clk);
      if (txen || txd != 0 || in_ready) bad++;
    end
    in_data = '0;
    check(bad == 0, "R6 data ignored while not valid", bad, 0);
  endtask

  task automatic t_single();
    int base = frames_done;
    send_frame(1, 3);
    wait (frames_done == base + 1);
    check_frame(1, 3, "single byte R9");
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic t_long();
    int base = frames_done;
    send_frame(32, 9);
    wait (frames_done == base + 1);
    check_frame(32, 9, "32 bytes");
    check(gap_before >= GAP, "R7 gap before frame", gap_before, GAP);
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    int base = frames_done;
    int rl;
    rl = ready_low;
    fork
      begin
        send_frame(5, 21);
        send_frame(3, 40);
      end
    join_none
    wait (frames_done == base + 1);
    check_frame(5, 21, "first queued");
    wait (frames_done == base + 2);
    check_frame(3, 40, "second queued");
    check(gap_before == GAP, "R7 exact gap back to back", gap_before, GAP);
    check(ready_low == rl, "R8 ready held off in gap", ready_low - rl, 0);
    repeat (GAP + 4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_noise();
    t_single();
    t_long();
    t_back_to_back();
    check(zero_viol == 0, "R6 txd zero while txen low", zero_viol, 0);
    check(ready_consec == 0, "R4 ready never consecutive", ready_consec, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule